// File: doc/BRIEF.md
# Block Adder Engine over Shared Word RAM

This engine adds a block of 16-bit operand pairs that sit in a local single-port word RAM. Data are organised as records of four consecutive words. The first two words of a record are the operands. The last two words receive the result: the low word of the sum, then a word that carries the carry-out in bit 0. Once the host has loaded the RAM, it pulses a start input. The engine then visits every record in address order, doing one RAM access per engine step. When the last result word has been written, it raises a done flag that the host can poll.

The engine runs on the base clock throughout. Its stepping rate comes from a clock-enable divider, and a 2-bit rate select picks a divide ratio of 4, 8 or 16. With a 40 MHz base clock these ratios give engine rates of 10, 5 and 2.5 MHz. A block of N records therefore takes 4·N engine steps. The host's own loading and unloading of the RAM, and the host bus interface, are not part of the block.

Top module: `blkadd_engine`

## Requirements
- R1: After reset, busy, done, ram_en and ram_we are all 0.
- R2: A start pulse that arrives while the engine is idle launches a run. The run makes exactly 4·NUM_REC RAM accesses at addresses 0, 1, 2, … in that order, one address per access.
- R3: Inside each record, the accesses at address bits [1:0] = 0 and 1 are reads (ram_we=0), and the accesses at bits [1:0] = 2 and 3 are writes (ram_we=1).
- R4: The word written at bits [1:0] = 2 equals (A + B) mod 2^16. Here A is the word read at offset 0 and B is the word read at offset 1.
- R5: The word written at bits [1:0] = 3 holds the carry-out of A + B in bit 0 and zeros in bits 15:1.
- R6: rate_sel values 0, 1, 2 and 3 give divide ratios of 4, 8, 16 and 16. The k-th access of a run takes place at the k·D-th rising edge after the start edge. Done becomes visible after edge 4·NUM_REC·D.
- R7: Done rises after the last write, together with busy falling. It stays at 1, with no further RAM access, until the next accepted start, which clears it at the start edge.
- R8: A start pulse that arrives while busy is ignored. The timing, the addresses and the results of the run in progress are unchanged.
- R9: rate_sel is captured at the accepted start. Changing it during a run has no effect on that run's timing.
- R10: ram_en is high for exactly one base-clock cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for one block |
| rate_sel | input | 2 | Divide ratio select, captured at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | Block complete flag |
| ram_en | output | 1 | RAM access strobe, one cycle per access |
| ram_we | output | 1 | RAM write enable, qualifies ram_en |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, registered, held until the next read |

## Verification
A table of eight operand pairs is walked as records. It covers zero plus zero, a carry produced by an all-ones operand plus one, all-ones plus all-ones, two half-range values whose sum wraps to exactly zero with a carry, sums that stop one short of a carry, and ordinary mixed values. Together these separate the low-word result from the carry word and expose a wrong carry bit. The table is rotated between runs so that every record slot sees different data. Runs at every rate_sel value tell the divide ratios apart through the access spacing and the completion time. Two more runs inject a start pulse and a rate change while busy, which shows whether the engine restarts or retimes.

// File: rtl/blkadd_pkg.sv
package blkadd_pkg;
   localparam int unsigned REC_WORDS = 4;

   typedef enum logic [1:0] {
      PH_RD_A  = 2'd0,
      PH_RD_B  = 2'd1,
      PH_WR_LO = 2'd2,
      PH_WR_HI = 2'd3
   } phase_t;

   // extra doublings of the minimum divide ratio for each select code
   function automatic int unsigned rate_shift(input logic [1:0] s);
      case (s)
         2'd0:    return 0;
         2'd1:    return 1;
         default: return 2;
      endcase
   endfunction
endpackage

// File: rtl/blkadd_clk_en.sv
module blkadd_clk_en
   import blkadd_pkg::*;
#(
   parameter int unsigned MIN_LOG = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int unsigned CNT_W = MIN_LOG + 2;

   generate
      if (MIN_LOG < 1) begin : g_bad_log
         $error("blkadd_clk_en: MIN_LOG must be at least 1");
      end
   endgenerate

   logic [1:0]       sel_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   always_comb last = CNT_W'((32'd1 << (MIN_LOG + rate_shift(sel_q))) - 32'd1);
   assign tick = (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= 2'd0;
         cnt   <= '0;
      end else if (restart) begin
         sel_q <= sel;
         cnt   <= '0;
      end else if (tick) begin
         cnt   <= '0;
      end else begin
         cnt   <= cnt + CNT_W'(1);
      end
   end

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);  // R10
endmodule

// File: rtl/blkadd_add.sv
module blkadd_add #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         cout
);
   generate
      if (W < 2) begin : g_bad_w
         $error("blkadd_add: W must be at least 2");
      end
   endgenerate

   assign {cout, sum} = a + b;
endmodule

// File: rtl/blkadd_seq.sv
module blkadd_seq
   import blkadd_pkg::*;
#(
   parameter int unsigned NUM_REC = 2048,
   parameter int unsigned ADDR_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   output logic              busy,
   output logic              done,
   output logic              launch,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned     WORDS = NUM_REC * REC_WORDS;
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

   generate
      if (NUM_REC < 1 || WORDS > (64'd1 << ADDR_W)) begin : g_bad_span
         $error("blkadd_seq: NUM_REC records do not fit in ADDR_W bits");
      end
   endgenerate

   assign launch = start & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         addr <= '0;
      end else if (launch) begin
         busy <= 1'b1;
         done <= 1'b0;
         addr <= '0;
      end else if (busy && tick) begin
         if (addr == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
            addr <= '0;
         end else begin
            addr <= addr + ADDR_W'(1);
         end
      end
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick && addr != LAST && !start) |=> (addr == $past(addr) + ADDR_W'(1)));  // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);  // R7
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);  // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !tick) |=> (busy && addr == $past(addr)));  // R8
endmodule

// File: rtl/blkadd_engine.sv
module blkadd_engine
   import blkadd_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned NUM_REC = 2048,
   parameter int unsigned MIN_LOG = 2,
   parameter int unsigned ADDR_W  = $clog2(NUM_REC * 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        rate_sel,
   output logic              busy,
   output logic              done,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata
);
   logic              tick;
   logic              launch;
   logic [ADDR_W-1:0] addr;
   phase_t            ph;
   logic [DATA_W-1:0] opa_q;
   logic              carry_q;
   logic [DATA_W-1:0] sum_lo;
   logic              sum_co;

   blkadd_clk_en #(.MIN_LOG(MIN_LOG)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(launch), .sel(rate_sel), .tick(tick)
   );

   blkadd_seq #(.NUM_REC(NUM_REC), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
      .busy(busy), .done(done), .launch(launch), .addr(addr)
   );

   // operand B is still on ram_rdata when the low result word is written
   blkadd_add #(.W(DATA_W)) u_add (
      .a(opa_q), .b(ram_rdata), .sum(sum_lo), .cout(sum_co)
   );

   assign ph = phase_t'(addr[1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opa_q   <= '0;
         carry_q <= 1'b0;
      end else if (busy && tick) begin
         if (ph == PH_RD_B)  opa_q   <= ram_rdata;
         if (ph == PH_WR_LO) carry_q <= sum_co;
      end
   end

   assign ram_en   = busy & tick;
   assign ram_we   = ram_en & (ph == PH_WR_LO || ph == PH_WR_HI);
   assign ram_addr = addr;

   always_comb begin
      if (ph == PH_WR_HI) ram_wdata = {{(DATA_W-1){1'b0}}, carry_q};
      else                ram_wdata = sum_lo;
   end

   AST_HI_WORD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && ram_addr[1:0] == 2'b11) |-> (ram_wdata[DATA_W-1:1] == '0));  // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |-> (!ram_en && !ram_we));  // R7
endmodule

// File: tb/sim_blkadd_engine.sv
module sim_blkadd_engine;
   localparam int CLK_PERIOD = 10;
   localparam int NREC  = 8;
   localparam int DW    = 16;
   localparam int AW    = $clog2(NREC * 4);
   localparam int WORDS = NREC * 4;

   // operand pairs {A, B}
   localparam logic [31:0] VEC [0:7] = '{
      32'h0000_0000, 32'hFFFF_0001, 32'hFFFF_FFFF, 32'h8000_8000,
      32'h1234_4321, 32'h7FFF_8000, 32'h0001_FFFE, 32'hABCD_5432
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    rate_sel = 2'd0;
   logic          busy, done, ram_en, ram_we;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;
   logic [DW-1:0] ram_rdata = '0;
   logic [DW-1:0] mem [0:WORDS-1];

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int mon_on = 0, mon_k = 0, mon_err = 0, mon_base = 0, mon_div = 4;

   blkadd_engine #(.DATA_W(DW), .NUM_REC(NREC), .MIN_LOG(2), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel),
      .busy(busy), .done(done), .ram_en(ram_en), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // single-port RAM model with registered read data
   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) mem[ram_addr] = ram_wdata;
         else        ram_rdata <= mem[ram_addr];
      end
   end

   // access monitor: address order, read/write kind, spacing
   always @(negedge clk) begin
      if (mon_on != 0 && ram_en) begin
         mon_k = mon_k + 1;
         if (ram_addr != AW'(mon_k - 1)) mon_err = mon_err + 1;
         if (ram_we != (((mon_k - 1) % 4) >= 2)) mon_err = mon_err + 1;
         if (cyc != mon_base + mon_k * mon_div) mon_err = mon_err + 1;
         if (mon_k > WORDS) mon_err = mon_err + 1;
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_block(input logic [1:0] s, input int rot, input int inj,
                            input int chg, input bit was_done);
      int n;
      int seen;
      int elapsed;
      for (int i = 0; i < NREC; i++) begin
         mem[4*i]   = VEC[(i + rot) % 8][31:16];
         mem[4*i+1] = VEC[(i + rot) % 8][15:0];
         mem[4*i+2] = 16'hDEAD;
         mem[4*i+3] = 16'hBEEF;
      end
      mon_k = 0; mon_err = 0;
      mon_div = 4 << ((s > 2'd1) ? 2 : int'(s));
      @(negedge clk);
      rate_sel = s; start = 1'b1; mon_base = cyc; mon_on = 1;
      n = 0; seen = 0; elapsed = 0;
      while (seen == 0 && n < 4000) begin
         @(negedge clk);
         n++;
         start = (n == inj);
         if (n == chg) rate_sel = ~s;
         if (n == 1 && was_done) check("R7 done cleared by start", done, 0);
         if (n == 1) check("R2 busy after start", busy, 1);
         if (done) begin seen = 1; elapsed = cyc - (mon_base + 1); end
      end
      start = 1'b0;
      check("R6 completion cycles", elapsed, 4 * NREC * mon_div);
      check("R7 busy low at done", busy, 0);
      for (int i = 0; i < NREC; i++) begin
         logic [16:0] s17;
         s17 = {1'b0, VEC[(i + rot) % 8][31:16]} + {1'b0, VEC[(i + rot) % 8][15:0]};
         check("R4 low sum word", mem[4*i+2], s17[15:0]);
         check("R5 carry word", mem[4*i+3], {15'd0, s17[16]});
         check("R2 operand A untouched", mem[4*i], VEC[(i + rot) % 8][31:16]);
      end
      repeat (40) @(negedge clk);
      check("R7 done held", done, 1);
      check("R2 R3 R10 access order and spacing errors", mon_err, 0);
      check("R2 access count", mon_k, WORDS);
   endtask

   initial begin
      while (cyc < 150000) @(negedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 ram_en", ram_en, 0);
      check("R1 ram_we", ram_we, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after release", {busy, done, ram_en}, 0);

      // table walked at every select code
      for (int s = 0; s < 4; s++) run_block(2'(s), s, -1, -1, s != 0);
      // R8: start pulse in the middle of a divide-by-8 run
      run_block(2'd1, 5, 40, -1, 1);
      // R9: rate_sel changed to 3 during a divide-by-4 run
      run_block(2'd0, 6, -1, 30, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule